// File: doc/BRIEF.md
# Raster Mix and Compare Pixel Unit

This unit is the per-pixel arithmetic and logic core of a 2-D drawing engine. Every cycle it can accept one source pixel and one destination pixel, each held in the low bits of a 32-bit lane. It applies a mix function to the pair and returns the value to be written back, together with a write enable. The mix code comes from one of two 8-bit inputs, a foreground code and a background code. A per-pixel select bit chooses between them, so a pattern or mask bit can steer each pixel to either mix.

The mixes cover all sixteen two-input Boolean functions, unsigned maximum and minimum, saturating add, saturating subtract in both directions, and the average of the two pixels. The arithmetic runs through a ripple chain in which a per-bit mask decides whether each carry moves upward, so one lane can hold several independent sub-fields. A plane mask shields chosen bits of the destination from change. A colour-compare stage tests the destination against a reference colour and blocks the write when the selected condition is true. Addressing, word packing and pixel fetch are left to the surrounding engine.

Top module: `pix_mix_unit`

## Requirements
- R1: Mix codes 0x00 to 0x0F are Boolean functions. Bit k of the code is the result for the input pair (S,D) = (1,1) when k=0, (1,0) when k=1, (0,1) when k=2 and (0,0) when k=3. So 0x01 is S&D, 0x03 is S, 0x05 is D, 0x06 is S^D, 0x0A is ~D and 0x0F is all ones.
- R2: Code 0x10 gives the larger and code 0x11 the smaller of the two pixels, compared as unsigned values.
- R3: Code 0x12 gives S+D, clamped to the all-ones pixel value on overflow. Code 0x13 gives D-S and code 0x14 gives S-D, each clamped to zero on underflow.
- R4: Code 0x15 gives (S+D)/2 and keeps the carry out of the top pixel bit as the result's top bit.
- R5: In the adders a carry leaves bit n only when bit n of carryMask is 1. Overflow and underflow are judged from the gated carry out of the top pixel bit.
- R6: A bit of wrData takes the mix result only where planeMask is 1 and the bit lies inside the pixel. Every other bit equals dstPix.
- R7: ccFunc selects the compare condition on the destination D against the colour CC: 0 always, 1 D>CC, 2 D==CC, 3 D<CC, 4 never, 5 D>=CC, 6 D!=CC, 7 D<=CC. wrEn is 1 only for a valid pixel whose condition is false.
- R8: fgSel=1 applies fgMix and fgSel=0 applies bgMix.
- R9: pixSize encodes the pixel width as 0=1, 1=2, 2=4, 3=8 and 4=16 bits, and values above 4 act as 4. Operands, the compare colour and the saturation limits are all taken at that width.
- R10: Mix codes 0x16 to 0xFF return the destination pixel unchanged.
- R11: The result for a pixel presented with inValid=1 appears two clock edges later with outValid=1. A new pixel may be presented every cycle.
- R12: During reset and whenever outValid is 0, wrEn is 0 and outValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input pixel is present |
| srcPix | input | 32 | Source pixel lane |
| dstPix | input | 32 | Destination pixel lane |
| fgSel | input | 1 | 1 selects the foreground mix, 0 the background mix |
| fgMix | input | 8 | Foreground mix code |
| bgMix | input | 8 | Background mix code |
| pixSize | input | 3 | Pixel width code |
| carryMask | input | 32 | Per-bit carry propagation enable |
| planeMask | input | 32 | Per-bit write permission |
| ccFunc | input | 3 | Colour-compare condition |
| ccColor | input | 32 | Colour-compare reference |
| outValid | output | 1 | Result is present |
| wrData | output | 32 | Value to write back |
| wrEn | output | 1 | Write permitted |

## Verification
The mix result and the compare verdict are computed side by side on the same pixel. They come together in the same output cycle, where the plane mask reshapes the data while the compare alone decides the enable. The bench drives a single pixel through all eight compare conditions, once with the destination equal to the reference colour and once with it above. Upper garbage in the reference colour tests the width masking. Each data word and enable is judged against an independent model. A plane-mask case with a constant mix then shows that shielded bits keep the destination even when the write is allowed.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  typedef struct packed {
    logic cap1;
    logic cap2;
  } pmxStrobe_t;

  localparam logic [7:0] MIX_BOOL_LAST = 8'h0F;
  localparam logic [7:0] MIX_MAX       = 8'h10;
  localparam logic [7:0] MIX_MIN       = 8'h11;
  localparam logic [7:0] MIX_ADD_SAT   = 8'h12;
  localparam logic [7:0] MIX_DMS_SAT   = 8'h13;
  localparam logic [7:0] MIX_SMD_SAT   = 8'h14;
  localparam logic [7:0] MIX_AVG       = 8'h15;

  typedef enum logic [2:0] {
    CC_ALWAYS = 3'd0,
    CC_GT     = 3'd1,
    CC_EQ     = 3'd2,
    CC_LT     = 3'd3,
    CC_NEVER  = 3'd4,
    CC_GE     = 3'd5,
    CC_NE     = 3'd6,
    CC_LE     = 3'd7
  } ccCond_e;
endpackage

// File: rtl/pmx_ctrl.sv
module pmx_ctrl
  import pmx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  output pmxStrobe_t strobe,
  output logic       outValid
);
  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  always_comb begin
    strobe.cap1 = inValid;
    strobe.cap2 = stage1Valid;
  end

  assign outValid = stage2Valid;
endmodule

// File: rtl/pmx_datapath.sv
module pmx_datapath
  import pmx_pkg::*;
#(
  parameter int LANE_W   = 32,
  parameter int MIX_W    = 8,
  parameter int SIZE_W   = 3,
  parameter int MAX_SIZE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pmxStrobe_t        strobe,
  input  logic [LANE_W-1:0] srcPix,
  input  logic [LANE_W-1:0] dstPix,
  input  logic              fgSel,
  input  logic [MIX_W-1:0]  fgMix,
  input  logic [MIX_W-1:0]  bgMix,
  input  logic [SIZE_W-1:0] pixSize,
  input  logic [LANE_W-1:0] carryMask,
  input  logic [LANE_W-1:0] planeMask,
  input  logic [2:0]        ccFunc,
  input  logic [LANE_W-1:0] ccColor,
  output logic [LANE_W-1:0] wrData,
  output logic              wrEn
);
  localparam int CNT_W = $clog2(LANE_W) + 1;
  localparam int TOP_W = $clog2(LANE_W);

  // ---------------- stage 1: width decode, operand masking, compare
  logic [SIZE_W-1:0] sizeClamp;
  logic [CNT_W-1:0]  widthIn;
  logic [LANE_W-1:0] pixMaskIn;
  logic [LANE_W-1:0] srcM, dstM, ccM;
  logic              condTrue;

  assign sizeClamp = (pixSize > SIZE_W'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE) : pixSize;
  assign widthIn   = CNT_W'(1) << sizeClamp;

  for (genvar gi = 0; gi < LANE_W; gi++) begin : g_pixMask
    assign pixMaskIn[gi] = (CNT_W'(gi) < widthIn);
  end

  assign srcM = srcPix & pixMaskIn;
  assign dstM = dstPix & pixMaskIn;
  assign ccM  = ccColor & pixMaskIn;

  always_comb begin
    unique case (ccCond_e'(ccFunc))
      CC_ALWAYS: condTrue = 1'b1;
      CC_GT:     condTrue = dstM >  ccM;
      CC_EQ:     condTrue = dstM == ccM;
      CC_LT:     condTrue = dstM <  ccM;
      CC_NEVER:  condTrue = 1'b0;
      CC_GE:     condTrue = dstM >= ccM;
      CC_NE:     condTrue = dstM != ccM;
      CC_LE:     condTrue = dstM <= ccM;
      default:   condTrue = 1'b0;
    endcase
  end

  logic [LANE_W-1:0] s1Src, s1Dst, s1DstRaw, s1Carry, s1Plane, s1PixMask;
  logic [MIX_W-1:0]  s1Mix;
  logic [TOP_W-1:0]  s1TopBit;
  logic              s1Inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Src     <= '0;
      s1Dst     <= '0;
      s1DstRaw  <= '0;
      s1Carry   <= '0;
      s1Plane   <= '0;
      s1PixMask <= '0;
      s1Mix     <= '0;
      s1TopBit  <= '0;
      s1Inhibit <= 1'b1;
    end else if (strobe.cap1) begin
      s1Src     <= srcM;
      s1Dst     <= dstM;
      s1DstRaw  <= dstPix;
      s1Carry   <= carryMask;
      s1Plane   <= planeMask;
      s1PixMask <= pixMaskIn;
      s1Mix     <= fgSel ? fgMix : bgMix;
      s1TopBit  <= TOP_W'(widthIn - CNT_W'(1));
      s1Inhibit <= condTrue;
    end
  end

  // ---------------- stage 2: mix evaluation and plane merge
  // Ripple adder whose carry out of bit n is gated by msk[n]; returns
  // {gated carry out of bit topBit, sum}.
  function automatic logic [LANE_W:0] addChain(
    input logic [LANE_W-1:0] a,
    input logic [LANE_W-1:0] b,
    input logic [LANE_W-1:0] msk,
    input logic              cin,
    input logic [TOP_W-1:0]  topBit
  );
    logic              c;
    logic              topC;
    logic [LANE_W-1:0] s;
    c    = cin;
    topC = 1'b0;
    s    = '0;
    for (int i = 0; i < LANE_W; i++) begin
      s[i] = a[i] ^ b[i] ^ c;
      c    = ((a[i] & b[i]) | (a[i] & c) | (b[i] & c)) & msk[i];
      if (TOP_W'(i) == topBit) topC = c;
    end
    return {topC, s};
  endfunction

  logic [LANE_W:0]   addR, dmsR, smdR;
  logic [LANE_W-1:0] boolR, avgR, topOnly, mixR, wrNext;

  assign addR    = addChain(s1Src, s1Dst, s1Carry, 1'b0, s1TopBit);
  assign dmsR    = addChain(s1Dst, ~s1Src & s1PixMask, s1Carry, 1'b1, s1TopBit);
  assign smdR    = addChain(s1Src, ~s1Dst & s1PixMask, s1Carry, 1'b1, s1TopBit);
  assign topOnly = s1PixMask ^ (s1PixMask >> 1);
  assign avgR    = ((addR[LANE_W-1:0] & s1PixMask) >> 1) | (addR[LANE_W] ? topOnly : '0);

  assign boolR = ({LANE_W{s1Mix[0]}} &  s1Src &  s1Dst)
               | ({LANE_W{s1Mix[1]}} &  s1Src & ~s1Dst)
               | ({LANE_W{s1Mix[2]}} & ~s1Src &  s1Dst)
               | ({LANE_W{s1Mix[3]}} & ~s1Src & ~s1Dst);

  always_comb begin
    if (s1Mix <= MIX_W'(MIX_BOOL_LAST)) begin
      mixR = boolR;
    end else begin
      unique case (s1Mix)
        MIX_W'(MIX_MAX):     mixR = (s1Src > s1Dst) ? s1Src : s1Dst;
        MIX_W'(MIX_MIN):     mixR = (s1Src < s1Dst) ? s1Src : s1Dst;
        MIX_W'(MIX_ADD_SAT): mixR = addR[LANE_W] ? s1PixMask : addR[LANE_W-1:0];
        MIX_W'(MIX_DMS_SAT): mixR = dmsR[LANE_W] ? dmsR[LANE_W-1:0] : '0;
        MIX_W'(MIX_SMD_SAT): mixR = smdR[LANE_W] ? smdR[LANE_W-1:0] : '0;
        MIX_W'(MIX_AVG):     mixR = avgR;
        default:             mixR = s1Dst;
      endcase
    end
  end

  assign wrNext = (mixR & s1Plane & s1PixMask) | (s1DstRaw & ~(s1Plane & s1PixMask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrData <= '0;
      wrEn   <= 1'b0;
    end else begin
      wrEn <= strobe.cap2 & ~s1Inhibit;
      if (strobe.cap2) wrData <= wrNext;
    end
  end
endmodule

// File: rtl/pix_mix_unit.sv
module pix_mix_unit
  import pmx_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int MIX_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [LANE_W-1:0] srcPix,
  input  logic [LANE_W-1:0] dstPix,
  input  logic              fgSel,
  input  logic [MIX_W-1:0]  fgMix,
  input  logic [MIX_W-1:0]  bgMix,
  input  logic [SIZE_W-1:0] pixSize,
  input  logic [LANE_W-1:0] carryMask,
  input  logic [LANE_W-1:0] planeMask,
  input  logic [2:0]        ccFunc,
  input  logic [LANE_W-1:0] ccColor,
  output logic              outValid,
  output logic [LANE_W-1:0] wrData,
  output logic              wrEn
);
  pmxStrobe_t strobe;

  pmx_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  pmx_datapath #(
    .LANE_W (LANE_W),
    .MIX_W  (MIX_W),
    .SIZE_W (SIZE_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .srcPix    (srcPix),
    .dstPix    (dstPix),
    .fgSel     (fgSel),
    .fgMix     (fgMix),
    .bgMix     (bgMix),
    .pixSize   (pixSize),
    .carryMask (carryMask),
    .planeMask (planeMask),
    .ccFunc    (ccFunc),
    .ccColor   (ccColor),
    .wrData    (wrData),
    .wrEn      (wrEn)
  );
endmodule

// File: rtl/pix_mix_unit_chk.sv
module pix_mix_unit_chk #(
  parameter int LANE_W = 32,
  parameter int MIX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic [LANE_W-1:0] dstPix,
  input logic              fgSel,
  input logic [MIX_W-1:0]  fgMix,
  input logic [MIX_W-1:0]  bgMix,
  input logic [LANE_W-1:0] planeMask,
  input logic [2:0]        ccFunc,
  input logic              outValid,
  input logic [LANE_W-1:0] wrData,
  input logic              wrEn
);
  logic              v1, v2;
  logic [LANE_W-1:0] dst1, dst2, pl1, pl2;
  logic [2:0]        cc1, cc2;
  logic [MIX_W-1:0]  mx1, mx2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0;
      dst1 <= '0; dst2 <= '0; pl1 <= '0; pl2 <= '0;
      cc1 <= '0; cc2 <= '0; mx1 <= '0; mx2 <= '0;
    end else begin
      v1 <= inValid;  v2 <= v1;
      dst1 <= dstPix; dst2 <= dst1;
      pl1 <= planeMask; pl2 <= pl1;
      cc1 <= ccFunc;  cc2 <= cc1;
      mx1 <= fgSel ? fgMix : bgMix; mx2 <= mx1;
    end
  end

  // R11
  latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n) outValid == v2);
  // R12
  wren_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) wrEn |-> outValid);
  // R6
  plane_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (((wrData ^ dst2) & ~pl2) == '0));
  // R7
  cc_never_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && cc2 == 3'd4) |-> wrEn);
  // R7
  cc_always_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && cc2 == 3'd0) |-> !wrEn);
  // R10
  undefined_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && mx2 > MIX_W'(8'h15)) |-> (wrData == dst2));
endmodule

bind pix_mix_unit pix_mix_unit_chk #(.LANE_W(LANE_W), .MIX_W(MIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inValid   (inValid),
  .dstPix    (dstPix),
  .fgSel     (fgSel),
  .fgMix     (fgMix),
  .bgMix     (bgMix),
  .planeMask (planeMask),
  .ccFunc    (ccFunc),
  .outValid  (outValid),
  .wrData    (wrData),
  .wrEn      (wrEn)
);

// File: tb/pix_mix_unit_test.sv
module pix_mix_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] srcPix = '0, dstPix = '0;
  logic        fgSel = 1'b1;
  logic [7:0]  fgMix = 8'h03, bgMix = 8'h05;
  logic [2:0]  pixSize = 3'd3;
  logic [31:0] carryMask = '1, planeMask = '1;
  logic [2:0]  ccFunc = 3'd4;
  logic [31:0] ccColor = '0;
  logic        outValid, wrEn;
  logic [31:0] wrData;

  int tests = 0;
  int fails = 0;
  logic [31:0] gotData;
  logic        gotEn, gotV;

  always #10 clk = ~clk;

  pix_mix_unit uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .srcPix(srcPix), .dstPix(dstPix),
    .fgSel(fgSel), .fgMix(fgMix), .bgMix(bgMix), .pixSize(pixSize),
    .carryMask(carryMask), .planeMask(planeMask), .ccFunc(ccFunc), .ccColor(ccColor),
    .outValid(outValid), .wrData(wrData), .wrEn(wrEn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] widthMask(input logic [2:0] sz);
    int w = 1 << ((sz > 3'd4) ? 4 : int'(sz));
    return (32'h1 << w) - 32'h1;
  endfunction

  // Independent model, full carry chain assumed.
  function automatic logic [31:0] model(input logic [7:0] code, input logic [31:0] s,
                                        input logic [31:0] d, input logic [2:0] sz,
                                        input logic [31:0] pl);
    logic [31:0] pm = widthMask(sz);
    longint S = longint'(s & pm);
    longint D = longint'(d & pm);
    longint M = longint'(pm);
    longint r;
    case (code)
      8'h00: r = 0;          8'h01: r = S & D;       8'h02: r = S & ~D;     8'h03: r = S;
      8'h04: r = ~S & D;     8'h05: r = D;           8'h06: r = S ^ D;      8'h07: r = S | D;
      8'h08: r = ~S & ~D;    8'h09: r = S ^ ~D;      8'h0A: r = ~D;         8'h0B: r = S | ~D;
      8'h0C: r = ~S;         8'h0D: r = ~S | D;      8'h0E: r = ~S | ~D;    8'h0F: r = -1;
      8'h10: r = (S > D) ? S : D;
      8'h11: r = (S < D) ? S : D;
      8'h12: r = (S + D > M) ? M : S + D;
      8'h13: r = (D >= S) ? D - S : 0;
      8'h14: r = (S >= D) ? S - D : 0;
      8'h15: r = (S + D) / 2;
      default: r = D;
    endcase
    return (32'(r) & pl & pm) | (d & ~(pl & pm));
  endfunction

  function automatic logic ccHolds(input logic [2:0] f, input logic [31:0] d,
                                   input logic [31:0] c, input logic [2:0] sz);
    logic [31:0] pm = widthMask(sz);
    logic [31:0] D = d & pm;
    logic [31:0] C = c & pm;
    case (f)
      3'd0: return 1'b1;     3'd1: return D > C;   3'd2: return D == C;  3'd3: return D < C;
      3'd4: return 1'b0;     3'd5: return D >= C;  3'd6: return D != C;  default: return D <= C;
    endcase
  endfunction

  task automatic fire();
    @(negedge clk); inValid = 1'b1;
    @(negedge clk); inValid = 1'b0;
    @(negedge clk);
    gotData = wrData; gotEn = wrEn; gotV = outValid;
  endtask

  task automatic mixOne(input string tag, input logic [7:0] code, input logic [31:0] s,
                        input logic [31:0] d, input logic [31:0] exp);
    fgSel = 1'b1; fgMix = code; srcPix = s; dstPix = d;
    fire();
    check(tag, gotData, exp);
  endtask

  task automatic testReset();
    check("R12 reset outValid", {31'b0, outValid}, 32'h0);
    check("R12 reset wrEn", {31'b0, wrEn}, 32'h0);
  endtask

  task automatic testBoolean();
    for (int c = 0; c < 16; c++)
      mixOne($sformatf("R1 bool code %0d", c), 8'(c), 32'hCA, 32'hAC,
             model(8'(c), 32'hCA, 32'hAC, 3'd3, '1));
  endtask

  task automatic testMaxMin();
    mixOne("R2 max", 8'h10, 32'h3C, 32'hC3, 32'hC3);
    mixOne("R2 min", 8'h11, 32'h3C, 32'hC3, 32'h3C);
  endtask

  task automatic testSaturate();
    mixOne("R3 add saturates", 8'h12, 32'hF0, 32'h20, 32'hFF);
    mixOne("R3 add plain", 8'h12, 32'h10, 32'h20, 32'h30);
    mixOne("R3 D-S floors", 8'h13, 32'h20, 32'h10, 32'h00);
    mixOne("R3 D-S plain", 8'h13, 32'h10, 32'h50, 32'h40);
    mixOne("R3 S-D plain", 8'h14, 32'h30, 32'h10, 32'h20);
    mixOne("R3 S-D floors", 8'h14, 32'h05, 32'h06, 32'h00);
  endtask

  task automatic testAverage();
    mixOne("R4 avg with carry", 8'h15, 32'hFF, 32'h01, 32'h80);
    mixOne("R4 avg plain", 8'h15, 32'h10, 32'h31, 32'h20);
  endtask

  task automatic testCarryMask();
    carryMask = 32'h0;
    mixOne("R5 no carries", 8'h12, 32'h0F, 32'h01, 32'h0E);
    carryMask = 32'h7;
    mixOne("R5 partial chain", 8'h12, 32'h0F, 32'h01, 32'h00);
    carryMask = 32'h7F;
    mixOne("R5 top carry gated, no clamp", 8'h12, 32'hF0, 32'h20, 32'h10);
    carryMask = '1;
  endtask

  task automatic testPlaneMask();
    planeMask = 32'h0F;
    mixOne("R6 plane mask", 8'h0F, 32'h00, 32'h123456A0, 32'h123456AF);
    planeMask = '1;
    mixOne("R6 bits above pixel keep dst", 8'h0F, 32'h0, 32'hABCD0000, 32'hABCD00FF);
  endtask

  task automatic testCompare();
    ccColor = 32'hFFFFFF40;
    for (int f = 0; f < 8; f++) begin
      ccFunc = 3'(f);
      mixOne($sformatf("R7 data cond %0d", f), 8'h03, 32'h11, 32'h40, 32'h11);
      check($sformatf("R7 wrEn eq cond %0d", f), {31'b0, gotEn},
            {31'b0, !ccHolds(3'(f), 32'h40, ccColor, 3'd3)});
      mixOne($sformatf("R9 data cond %0d above", f), 8'h03, 32'h11, 32'h50, 32'h11);
      check($sformatf("R7 wrEn gt cond %0d", f), {31'b0, gotEn},
            {31'b0, !ccHolds(3'(f), 32'h50, ccColor, 3'd3)});
    end
    ccFunc = 3'd4; ccColor = '0;
  endtask

  task automatic testSelect();
    fgMix = 8'h03; bgMix = 8'h05; srcPix = 32'h5A; dstPix = 32'hA5;
    fgSel = 1'b1; fire();
    check("R8 foreground picks S", gotData, 32'h5A);
    fgSel = 1'b0; fire();
    check("R8 background picks D", gotData, 32'hA5);
    fgSel = 1'b1;
  endtask

  task automatic testWidths();
    pixSize = 3'd2;
    mixOne("R9 4-bit add clamp", 8'h12, 32'hC, 32'h1239, 32'h123F);
    pixSize = 3'd0;
    mixOne("R9 1-bit xor", 8'h06, 32'h1, 32'hFFFFFFFF, 32'hFFFFFFFE);
    pixSize = 3'd4;
    mixOne("R9 16-bit add clamp", 8'h12, 32'hFFFF, 32'h0001, 32'h0000FFFF);
    pixSize = 3'd7;
    mixOne("R9 size 7 acts as 16", 8'h10, 32'h0001_8000, 32'h0000_7FFF, 32'h0000_8000);
    pixSize = 3'd1;
    mixOne("R9 2-bit D-S", 8'h13, 32'h1, 32'h3, 32'h2);
    pixSize = 3'd3;
  endtask

  task automatic testUndefined();
    mixOne("R10 code 0x16", 8'h16, 32'h77, 32'h9988, 32'h9988);
    mixOne("R10 code 0xFF", 8'hFF, 32'h77, 32'h42, 32'h42);
  endtask

  task automatic testStream();
    fgSel = 1'b1; fgMix = 8'h03; dstPix = 32'h0;
    @(negedge clk); inValid = 1'b1; srcPix = 32'h11;
    @(negedge clk); srcPix = 32'h22;
    @(negedge clk); srcPix = 32'h33;
    check("R11 first result", wrData, 32'h11);
    check("R11 first valid", {31'b0, outValid}, 32'h1);
    @(negedge clk); inValid = 1'b0;
    check("R11 second result", wrData, 32'h22);
    @(negedge clk);
    check("R11 third result", wrData, 32'h33);
    check("R11 third valid", {31'b0, outValid}, 32'h1);
    @(negedge clk);
    check("R12 valid drops", {31'b0, outValid}, 32'h0);
    check("R12 wrEn drops", {31'b0, wrEn}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    testBoolean();
    testMaxMin();
    testSaturate();
    testAverage();
    testCarryMask();
    testPlaneMask();
    testCompare();
    testSelect();
    testWidths();
    testUndefined();
    testStream();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule